// File: doc/BRIEF.md
# Windowed Clock Frequency Monitor

This block watches two clocks that are foreign to its own reference clock and reports when they misbehave. Each monitored clock passes through a flop synchroniser into the reference domain. There its rising edges are found by comparing the last two synchronised samples. A stop detector per clock counts reference cycles since the last edge and declares the clock stopped when the count reaches a programmed length.

The fast clock also feeds a frequency monitor. It counts synchronised rising edges over a fixed window of reference cycles, saturating at the counter's largest value. At the end of each window it compares the count with an upper and a lower bound that software sets. A count strictly above the upper bound, or strictly below the lower bound, raises the range flag.

The three flags are sticky. Software clears them by writing 1 to the matching bit of the clear input. A single interrupt output is the OR of every flag whose interrupt enable bit is set. Each detector has its own enable, so range checking and stop detection can be used on their own.

Top module: `clk_freq_guard`

## Requirements
- R1: After synchronous reset, `flags` is 3'b000 and `irq` is 0.
- R2: With `det_en[2]` set, synchronised rising edges of `mon_fast` are counted over each window of WIN_LEN reference cycles. If the count at the end of the window is greater than `upper_bnd`, flag bit 2 (range) is set.
- R3: If the window count is less than `lower_bnd`, flag bit 2 is set. A count equal to either bound does not set it.
- R4: The edge count saturates at 2**CNT_W-1 and never wraps. A clock giving more edges than that in a window reads as exactly 2**CNT_W-1.
- R5: While `det_en[2]` is 0, the window and edge counters are held at zero, no comparison is made, and flag bit 2 is not set.
- R6: With `det_en[0]` (for `mon_fast`) or `det_en[1]` (for `mon_slow`) set, STOP_LEN reference cycles without a synchronised rising edge set flag bit 0 or bit 1 respectively. Gaps between edges shorter than STOP_LEN never set the flag.
- R7: A stop detector whose enable bit is 0 never sets its flag, even when its clock is stopped.
- R8: Flags stay set after the fault goes away. Writing 1 to bit i of `flag_clr` clears flag bit i only. A set condition in the same cycle wins over the clear.
- R9: `irq` is 1 exactly when some flag bit i and `irq_en[i]` are both 1. The bit order of `irq_en` is the same as for `flags`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_fast | input | 1 | Fast monitored clock, asynchronous to `clk` |
| mon_slow | input | 1 | Slow monitored clock, asynchronous to `clk` |
| det_en | input | 3 | Detector enables: bit0 fast stop, bit1 slow stop, bit2 range |
| irq_en | input | 3 | Interrupt enables, same bit order as `flags` |
| upper_bnd | input | CNT_W | Upper bound of the edge count |
| lower_bnd | input | CNT_W | Lower bound of the edge count |
| flag_clr | input | 3 | Write-1-to-clear strobe per flag |
| flags | output | 3 | Sticky flags: bit0 fast stopped, bit1 slow stopped, bit2 out of range |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with WIN_LEN=64, CNT_W=5 and STOP_LEN=16, in place of the default 1024-cycle window, 10-bit count and 256-cycle stop length. With these values a monitored clock toggling every reference cycle gives 32 edges per window. That exceeds the 31 the counter can hold, so saturation is reached and can be told apart from wrap-around through the bounds. The short stop length lets both a sub-threshold gap and a real stop be shown within a few dozen cycles. The bounds and window are swept through a vector table with several monitored periods, including a stopped clock against a zero and a non-zero lower bound.

// File: rtl/cfm_pkg.sv
package cfm_pkg;

    // Flag and enable bit positions shared by ports and internal vectors.
    localparam int FLAG_FAST_STOP = 0;
    localparam int FLAG_SLOW_STOP = 1;
    localparam int FLAG_RANGE     = 2;
    localparam int NUM_FLAGS      = 3;
    localparam int NUM_MON        = 2;

    // Result of one window comparison, valid for a single cycle.
    typedef struct packed {
        logic too_high;
        logic too_low;
    } range_verdict_t;

    // Saturating increment on a generic 32-bit carrier.
    function automatic logic [31:0] sat_inc(input logic [31:0] v, input logic [31:0] vmax);
        return (v >= vmax) ? vmax : v + 32'd1;
    endfunction

endpackage

// File: rtl/cfm_edge_sync.sv
module cfm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    // chain[0..STAGES-1] synchroniser, chain[STAGES] edge history
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= async_in;
    end

    generate
        for (genvar i = 1; i <= STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= chain[i-1];
            end
        end
    endgenerate

    assign rise = chain[STAGES-1] & ~chain[STAGES];

    // A detected edge cannot repeat in the very next cycle.
    p_rise_single_r6: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/cfm_stop_det.sv
module cfm_stop_det #(
    parameter int STOP_LEN = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic rise,
    output logic stopped
);
    localparam int SW = $clog2(STOP_LEN + 1);
    localparam logic [SW-1:0] LIMIT = SW'(STOP_LEN);

    logic [SW-1:0] idle_cnt;

    always_ff @(posedge clk) begin
        if (rst || !en || rise)   idle_cnt <= '0;
        else if (idle_cnt != LIMIT) idle_cnt <= idle_cnt + 1'b1;
    end

    assign stopped = (idle_cnt == LIMIT);

    // An edge always revives the detector on the next cycle.
    p_edge_revives_r6: assert property (@(posedge clk) disable iff (rst)
        rise |=> !stopped);
    // A disabled detector reports nothing on the next cycle.
    p_off_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !en |=> !stopped);
    // Once stopped, stays stopped until an edge or disable.
    p_stop_holds_r6: assert property (@(posedge clk) disable iff (rst)
        (stopped && en && !rise) |=> stopped);

endmodule

// File: rtl/cfm_freq_win.sv
module cfm_freq_win
    import cfm_pkg::*;
#(
    parameter int WIN_LEN = 1024,
    parameter int CNT_W   = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             rise,
    input  logic [CNT_W-1:0] upper,
    input  logic [CNT_W-1:0] lower,
    output range_verdict_t   verdict
);
    localparam int WW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
    localparam logic [WW-1:0]    WIN_LAST = WW'(WIN_LEN - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};

    logic [WW-1:0]    win_cnt;
    logic [CNT_W-1:0] edge_cnt;
    logic [CNT_W-1:0] edge_next;
    logic             win_last;

    assign win_last  = (win_cnt == WIN_LAST);
    assign edge_next = rise ? CNT_W'(sat_inc(32'(edge_cnt), 32'(CNT_MAX))) : edge_cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            win_cnt  <= '0;
            edge_cnt <= '0;
            verdict  <= '0;
        end else begin
            verdict.too_high <= win_last && (edge_next > upper);
            verdict.too_low  <= win_last && (edge_next < lower);
            if (win_last) begin
                win_cnt  <= '0;
                edge_cnt <= '0;
            end else begin
                win_cnt  <= win_cnt + 1'b1;
                edge_cnt <= edge_next;
            end
        end
    end

    // Disabled monitor: counters parked at zero, no verdict.
    p_idle_zero_r5: assert property (@(posedge clk) disable iff (rst)
        !en |=> (edge_cnt == '0 && win_cnt == '0));
    p_idle_noverdict_r5: assert property (@(posedge clk) disable iff (rst)
        !en |=> (verdict == '0));
    // A saturated count stays saturated within the window.
    p_sat_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (en && edge_cnt == CNT_MAX && !win_last) |=> (edge_cnt == CNT_MAX));
    // A verdict only follows the last cycle of a window.
    p_verdict_at_end_r2: assert property (@(posedge clk) disable iff (rst)
        (verdict != '0) |-> ($past(win_cnt) == WIN_LAST));

endmodule

// File: rtl/clk_freq_guard.sv
module clk_freq_guard
    import cfm_pkg::*;
#(
    parameter int WIN_LEN     = 1024,
    parameter int CNT_W       = 10,
    parameter int STOP_LEN    = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mon_fast,
    input  logic             mon_slow,
    input  logic [2:0]       det_en,
    input  logic [2:0]       irq_en,
    input  logic [CNT_W-1:0] upper_bnd,
    input  logic [CNT_W-1:0] lower_bnd,
    input  logic [2:0]       flag_clr,
    output logic [2:0]       flags,
    output logic             irq
);
    logic [NUM_MON-1:0]   mon_in;
    logic [NUM_MON-1:0]   mon_rise;
    logic [NUM_MON-1:0]   mon_stopped;
    range_verdict_t       verdict;
    logic [NUM_FLAGS-1:0] set_vec;
    logic [NUM_FLAGS-1:0] flag_q;

    assign mon_in[FLAG_FAST_STOP] = mon_fast;
    assign mon_in[FLAG_SLOW_STOP] = mon_slow;

    generate
        for (genvar m = 0; m < NUM_MON; m++) begin : g_mon
            cfm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk      (clk),
                .rst      (rst),
                .async_in (mon_in[m]),
                .rise     (mon_rise[m])
            );
            cfm_stop_det #(.STOP_LEN(STOP_LEN)) u_stop (
                .clk     (clk),
                .rst     (rst),
                .en      (det_en[m]),
                .rise    (mon_rise[m]),
                .stopped (mon_stopped[m])
            );
        end
    endgenerate

    cfm_freq_win #(.WIN_LEN(WIN_LEN), .CNT_W(CNT_W)) u_win (
        .clk     (clk),
        .rst     (rst),
        .en      (det_en[FLAG_RANGE]),
        .rise    (mon_rise[FLAG_FAST_STOP]),
        .upper   (upper_bnd),
        .lower   (lower_bnd),
        .verdict (verdict)
    );

    assign set_vec[FLAG_FAST_STOP] = mon_stopped[FLAG_FAST_STOP];
    assign set_vec[FLAG_SLOW_STOP] = mon_stopped[FLAG_SLOW_STOP];
    assign set_vec[FLAG_RANGE]     = verdict.too_high | verdict.too_low;

    // Sticky flags: clear by write-1, set wins in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) flag_q <= '0;
        else     flag_q <= (flag_q & ~flag_clr) | set_vec;
    end

    assign flags = flag_q;
    assign irq   = |(flag_q & irq_en);

    // Uncleared flags never drop.
    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flag_q & $past(flag_q & ~flag_clr)) == $past(flag_q & ~flag_clr)));
    // A clear with no coincident set empties the bit.
    p_w1c_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flag_q & $past(flag_clr & ~set_vec)) == '0));
    // A new flag bit needs a set condition one cycle earlier.
    p_set_source_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(set_vec)) == '0));
    // No enabled interrupt, no interrupt.
    p_irq_masked_r9: assert property (@(posedge clk) disable iff (rst)
        (irq_en == '0) |-> !irq);

endmodule

// File: tb/sim_clk_freq_guard.sv
module sim_clk_freq_guard;
    localparam int CLK_PERIOD = 10;
    localparam int WIN_LEN    = 64;
    localparam int CNT_W      = 5;
    localparam int STOP_LEN   = 16;

    typedef struct packed {
        int half;   // monitored half period in ref cycles, 0 = stopped
        int lo;
        int up;
        int expf;   // expected range flag
    } vec_t;

    // Edge counts per 64-cycle window: half1 -> 32 (saturates 31), half2 -> 16, half4 -> 8, half8 -> 4
    localparam vec_t VEC [9] = '{
        '{2, 12, 20, 0},   // R2/R3 in range
        '{2, 18, 25, 1},   // R3 below lower
        '{2,  5, 12, 1},   // R2 above upper
        '{4,  6, 10, 0},
        '{8,  6, 10, 1},
        '{1, 31, 31, 0},   // R4 saturated at 31 equals both bounds
        '{1,  0, 30, 1},   // R4 saturated above upper
        '{0,  0, 31, 0},   // R3 count 0 equals lower bound
        '{0,  1, 31, 1}    // R3 count 0 below lower bound
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             mon_fast = 1'b0;
    logic             mon_slow = 1'b0;
    logic [2:0]       det_en = '0;
    logic [2:0]       irq_en = '0;
    logic [CNT_W-1:0] upper_bnd = '0;
    logic [CNT_W-1:0] lower_bnd = '0;
    logic [2:0]       flag_clr = '0;
    logic [2:0]       flags;
    logic             irq;

    int checks = 0;
    int failures = 0;
    int f_half = 0, f_ph = 0;
    int s_half = 0, s_ph = 0;
    bit done = 0;

    clk_freq_guard #(
        .WIN_LEN(WIN_LEN), .CNT_W(CNT_W), .STOP_LEN(STOP_LEN), .SYNC_STAGES(2)
    ) u0 (
        .clk(clk), .rst(rst), .mon_fast(mon_fast), .mon_slow(mon_slow),
        .det_en(det_en), .irq_en(irq_en), .upper_bnd(upper_bnd),
        .lower_bnd(lower_bnd), .flag_clr(flag_clr), .flags(flags), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitored clock generators, stepped on the inactive edge.
    always @(negedge clk) begin
        if (f_half == 0) f_ph <= 0;
        else if (f_ph >= f_half - 1) begin mon_fast <= ~mon_fast; f_ph <= 0; end
        else f_ph <= f_ph + 1;
        if (s_half == 0) s_ph <= 0;
        else if (s_ph >= s_half - 1) begin mon_slow <= ~mon_slow; s_ph <= 0; end
        else s_ph <= s_ph + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_flags(input logic [2:0] m);
        flag_clr = m;
        cyc(1);
        flag_clr = '0;
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        cyc(3);
        // R1 reset state
        chk("R1 flags", int'(flags), 0);
        chk("R1 irq", int'(irq), 0);
        rst = 1'b0;
        cyc(2);

        // Table walk: range monitor only
        for (int i = 0; i < 9; i++) begin
            det_en = '0;
            f_half = VEC[i].half;
            lower_bnd = CNT_W'(VEC[i].lo);
            upper_bnd = CNT_W'(VEC[i].up);
            cyc(6);
            clear_flags(3'b111);
            irq_en = 3'b100;
            det_en = 3'b100;
            cyc(3 * WIN_LEN + 10);
            chk($sformatf("R2/R3/R4 vec%0d range flag", i), int'(flags[2]), VEC[i].expf);
            chk($sformatf("R9 vec%0d irq", i), int'(irq), VEC[i].expf);
            chk($sformatf("R7 vec%0d stop flags off", i), int'(flags[1:0]), 0);
        end

        // R5 disabled monitor with stopped clock and lower bound 31
        det_en = '0; f_half = 0; lower_bnd = 5'd31; upper_bnd = 5'd31;
        cyc(4); clear_flags(3'b111);
        cyc(3 * WIN_LEN + 10);
        chk("R5 disabled no range flag", int'(flags), 0);

        // R6 fast stop detector
        irq_en = 3'b000; f_half = 2; det_en = 3'b001;
        cyc(10); clear_flags(3'b111);
        cyc(100);
        chk("R6 fast running no flag", int'(flags[0]), 0);
        f_half = 0;
        cyc(40);
        chk("R6 fast stopped flag", int'(flags[0]), 1);
        chk("R9 masked irq", int'(irq), 0);
        irq_en = 3'b001;
        cyc(1);
        chk("R9 enabled irq", int'(irq), 1);
        f_half = 2;
        cyc(50);
        chk("R8 sticky after recovery", int'(flags[0]), 1);
        clear_flags(3'b001);
        cyc(2);
        chk("R8 w1c clears", int'(flags[0]), 0);
        chk("R9 irq drops", int'(irq), 0);

        // R6 slow stop detector: short gaps then a stop
        irq_en = 3'b000; s_half = 6; det_en = 3'b010;
        cyc(10); clear_flags(3'b111);
        cyc(100);
        chk("R6 slow gap 12 no flag", int'(flags[1]), 0);
        s_half = 0;
        cyc(40);
        chk("R6 slow stopped flag", int'(flags[1]), 1);

        // R8 selective clear
        f_half = 0; det_en = 3'b011;
        cyc(40);
        chk("R8 both stop flags", int'(flags), 3);
        det_en = 3'b000;
        cyc(2);
        clear_flags(3'b001);
        cyc(1);
        chk("R8 clear bit0 only", int'(flags), 2);
        clear_flags(3'b010);
        cyc(1);
        chk("R8 clear bit1", int'(flags), 0);

        // R7 disabled stop detectors with both clocks stopped
        cyc(60);
        chk("R7 disabled no stop flags", int'(flags), 0);

        // R1 reset mid-run clears flags
        det_en = 3'b011;
        cyc(40);
        chk("R6 flags before reset", int'(flags), 3);
        rst = 1'b1;
        cyc(2);
        chk("R1 reset clears flags", int'(flags), 0);
        rst = 1'b0;
        det_en = '0;
        cyc(2);

        done = 1;
        summary();
        $finish;
    end

endmodule